// File: doc/BRIEF.md
# Opcode-Steered Nibble Register Unit

This block is a small single-cycle execution unit built around three 4-bit registers, here called A, B and C. Every rising clock edge it reads a 3-bit opcode and a 4-bit operand and carries out exactly one action. The actions are: clear everything, load A or B from the operand, copy C back into B, or write a result into C. That result is the sum, the left-shifted B, or the bitwise AND. A separate compare action updates a greater-than flag. Addition also records its carry-out in an overflow flag.

The decoder turns the opcode into per-register write enables, a clear, and multiplexer selects. B's input chooses between the operand and C. C's input chooses among the adder, the shifter and the AND unit. The surrounding logic sequences opcodes one per cycle and observes the register and flag outputs directly.

Top module: `nibble_alu_core`

## Requirements
- R1: A synchronous active-high `rst` clears A, B, C, `ovf_q` and `gt_q` at the next rising edge, and it takes priority over any opcode presented in the same cycle.
- R2: Opcode 3'b000 (clear) sets A, B, C, `ovf_q` and `gt_q` to zero at the next rising edge.
- R3: Opcode 3'b001 loads `din` into A, and opcode 3'b010 loads `din` into B. In both cases every other register and both flags hold.
- R4: Opcode 3'b011 writes into B the value C held before the edge. A, C and the flags hold.
- R5: Opcode 3'b100 writes the low 4 bits of the unsigned sum A+B into C and sets `ovf_q` to the carry out of bit 3.
- R6: Opcode 3'b101 writes B shifted left by `din[3:2]` places (0 to 3) into C. Bits shifted out are lost and zeros enter at bit 0.
- R7: Opcode 3'b110 sets `gt_q` to 1 exactly when A > B as unsigned numbers, and to 0 otherwise. No data register changes.
- R8: Opcode 3'b111 writes the bitwise AND of A and B into C.
- R9: `ovf_q` changes only on opcode 3'b100, clear or reset, and `gt_q` changes only on opcode 3'b110, clear or reset.
- R10: A register that the current opcode does not write keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 3 | Opcode for this cycle |
| din | input | 4 | Operand; bits 3:2 also give the shift distance |
| a_q | output | 4 | Register A |
| b_q | output | 4 | Register B |
| c_q | output | 4 | Register C |
| ovf_q | output | 1 | Carry out of the last addition |
| gt_q | output | 1 | Result of the last compare |

## Verification
Two functions meet in one cycle in two ways. Reset arrives together with a load opcode and must override it. The add opcode writes C and the overflow flag at the same edge, so both must come from one sum. The bench drives reset high alongside a load of 4'hF, and it runs sums that both do and do not carry. After each edge it compares every register and both flags against a behavioural model. It also runs a copy-back directly after a C write, which checks that B receives the freshly written C.

// File: rtl/nibble_alu_core.sv
module nibble_alu_core #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [W-1:0] din,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic [W-1:0] c_q,
  output logic         ovf_q,
  output logic         gt_q
);
  localparam logic [2:0] OP_CLR = 3'd0, OP_LDA = 3'd1, OP_LDB = 3'd2, OP_CPY = 3'd3,
                         OP_ADD = 3'd4, OP_SHL = 3'd5, OP_CMP = 3'd6, OP_AND = 3'd7;

  logic         clr, en_a, en_b, en_c, b_from_c, en_ovf, en_gt;
  logic [1:0]   c_sel;
  logic [W:0]   sum;
  logic [W-1:0] shl, conj, c_nxt, b_nxt;

  assign clr      = rst || (op == OP_CLR);
  assign en_a     = (op == OP_LDA);
  assign en_b     = (op == OP_LDB) || (op == OP_CPY);
  assign b_from_c = (op == OP_CPY);
  assign en_c     = (op == OP_ADD) || (op == OP_SHL) || (op == OP_AND);
  assign en_ovf   = (op == OP_ADD);
  assign en_gt    = (op == OP_CMP);
  assign c_sel    = (op == OP_ADD) ? 2'd0 : (op == OP_SHL) ? 2'd1 : 2'd2;

  assign sum  = {1'b0, a_q} + {1'b0, b_q};
  assign shl  = b_q << din[W-1:W-2];
  assign conj = a_q & b_q;

  always_comb begin
    case (c_sel)
      2'd0:    c_nxt = sum[W-1:0];
      2'd1:    c_nxt = shl;
      2'd2:    c_nxt = conj;
      default: c_nxt = '0;
    endcase
  end

  assign b_nxt = b_from_c ? c_q : din;

  always_ff @(posedge clk) begin
    if (clr) begin
      a_q   <= '0;
      b_q   <= '0;
      c_q   <= '0;
      ovf_q <= 1'b0;
      gt_q  <= 1'b0;
    end else begin
      if (en_a)   a_q   <= din;
      if (en_b)   b_q   <= b_nxt;
      if (en_c)   c_q   <= c_nxt;
      if (en_ovf) ovf_q <= sum[W];
      if (en_gt)  gt_q  <= (a_q > b_q);
    end
  end
endmodule

module nibble_alu_core_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   op,
  input logic [W-1:0] din,
  input logic [W-1:0] a_q,
  input logic [W-1:0] b_q,
  input logic [W-1:0] c_q,
  input logic         ovf_q,
  input logic         gt_q
);
  logic armed;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  a_r1_reset_clears: assert property (@(posedge clk)
    armed && $past(rst) |-> (a_q == '0) && (b_q == '0) && (c_q == '0) && !ovf_q && !gt_q);

  a_r5_sum_and_carry: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) == 3'd4 |->
      {ovf_q, c_q} == ({1'b0, $past(a_q)} + {1'b0, $past(b_q)}));

  a_r4_copy_back: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) == 3'd3 |-> b_q == $past(c_q) && c_q == $past(c_q));

  a_r6_shift: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) == 3'd5 |->
      c_q == W'($past(b_q) << $past(din[W-1:W-2])));

  a_r7_compare: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) == 3'd6 |->
      gt_q == ($past(a_q) > $past(b_q)) && $stable(a_q) && $stable(b_q) && $stable(c_q));

  a_r8_and: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) == 3'd7 |-> c_q == ($past(a_q) & $past(b_q)));

  a_r9_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) != 3'd4 && $past(op) != 3'd0 |-> $stable(ovf_q));

  a_r9_gt_hold: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(rst) && $past(op) != 3'd6 && $past(op) != 3'd0 |-> $stable(gt_q));
endmodule

bind nibble_alu_core nibble_alu_core_chk #(.W(W)) u_chk (.*);

// File: tb/sim_nibble_alu_core.sv
module sim_nibble_alu_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] op  = 3'd0;
  logic [3:0] din = 4'd0;
  logic [3:0] a_q, b_q, c_q;
  logic       ovf_q, gt_q;

  int total = 0, bad = 0;
  bit done = 0;
  int ma = 0, mb = 0, mc = 0, movf = 0, mgt = 0;

  always #10 clk = ~clk;

  nibble_alu_core u0 (.clk(clk), .rst(rst), .op(op), .din(din),
    .a_q(a_q), .b_q(b_q), .c_q(c_q), .ovf_q(ovf_q), .gt_q(gt_q));

  function automatic string tag_of(input logic r, input int o);
    if (r) return "R1";
    case (o)
      0: return "R2";
      1, 2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      6: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic r, input int o, input int d);
    int na, nb, nc, nov, ngt;
    string t;
    bit wa, wb, wc, wov, wgt;
    @(negedge clk);
    rst = r; op = 3'(o); din = 4'(d);
    na = ma; nb = mb; nc = mc; nov = movf; ngt = mgt;
    wa = 0; wb = 0; wc = 0; wov = 0; wgt = 0;
    if (r || o == 0) begin
      na = 0; nb = 0; nc = 0; nov = 0; ngt = 0;
      wa = 1; wb = 1; wc = 1; wov = 1; wgt = 1;
    end else case (o)
      1: begin na = d; wa = 1; end
      2: begin nb = d; wb = 1; end
      3: begin nb = mc; wb = 1; end
      4: begin nc = (ma + mb) % 16; nov = (ma + mb) / 16; wc = 1; wov = 1; end
      5: begin nc = (mb * (1 << (d / 4))) % 16; wc = 1; end
      6: begin ngt = (ma > mb) ? 1 : 0; wgt = 1; end
      default: begin nc = ma & mb; wc = 1; end
    endcase
    ma = na; mb = nb; mc = nc; movf = nov; mgt = ngt;
    @(negedge clk);
    t = tag_of(r, o);
    chk(wa ? t : "R10", "a_q", int'(a_q), ma);
    chk(wb ? t : "R10", "b_q", int'(b_q), mb);
    chk(wc ? t : "R10", "c_q", int'(c_q), mc);
    chk(wov ? t : "R9", "ovf_q", int'(ovf_q), movf);
    chk(wgt ? t : "R9", "gt_q", int'(gt_q), mgt);
  endtask

  initial begin
    step(1, 1, 15);          // R1: reset beats a load of 4'hF
    step(0, 1, 9);           // R3
    step(0, 2, 7);           // R3
    step(0, 4, 0);           // R5: 9+7 carries
    step(0, 3, 0);           // R4: copy freshly written C
    step(0, 6, 0);           // R7: 9 > 0
    step(0, 2, 9);
    step(0, 6, 0);           // R7: equal gives 0
    step(0, 2, 3);
    step(0, 4, 0);           // R5: 9+3 no carry
    step(0, 5, 12);          // R6: shift by 3
    step(0, 5, 4);           // R6: shift by 1
    step(0, 5, 3);           // R6: shift by 0
    step(0, 7, 0);           // R8
    step(0, 2, 15);
    step(0, 1, 15);
    step(0, 4, 0);           // R5: 15+15
    step(0, 0, 0);           // R2
    for (int i = 0; i < 400; i++)
      step(($urandom % 50) == 0, $urandom % 8, $urandom % 16);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule